// File: doc/BRIEF.md
# Carry-Word-Select Adder

This block adds two unsigned operands of a configurable width plus a carry-in bit. Instead of building two complete sum words, one for each possible carry-in, and discarding one, it builds two carry words only. A shared stage forms the bitwise propagate (XOR) and generate (AND) words. Two carry chains then run in parallel, one assuming an incoming carry of zero and one assuming an incoming carry of one. The real carry-in picks the final carry word, and a single row of XOR gates turns the propagate word and the chosen carry word into the one sum that is ever built.

The carry-one word is never smaller than the carry-zero word, bit for bit. Because of this, each selected carry bit needs only one AND-OR gate, `c0 | (cin & c1)`, rather than a full two-input multiplexer. The arithmetic is combinational. The result is captured in output registers with a synchronous active-high reset, so that it fits a registered datapath.

Top module: `cws_adder`

## Requirements
- R1: One rising clock edge after a, b and carry-in are sampled with reset low, the concatenation {cout_o, sum_o} equals a_i + b_i + cin_i, computed W+1 bits wide.
- R2: At every rising edge where rst is high, sum_o and cout_o become all zeros, whatever the operands are.
- R3: At every bit position, a 1 in the carry word built for carry-in zero implies a 1 at the same position in the carry word built for carry-in one.
- R4: The selected carry word equals the carry-zero word when cin_i is 0 and the carry-one word when cin_i is 1. For example, all-ones plus zero with carry-in 0 gives sum all ones and cout 0.
- R5: With carry-in 1, a carry ripples through a full run of propagate bits. For example, all-ones plus zero plus 1 gives sum 0 and cout 1.
- R6: cout_o is the top bit of the selected carry word. For example, all-ones plus all-ones with carry-in 1 gives cout 1 and sum all ones.
- R7: sum_o bit 0 equals a_i[0] XOR b_i[0] XOR cin_i, independent of the upper operand bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | W | Registered sum |
| cout_o | output | 1 | Registered carry-out |

## Verification
Every result of this adder is due exactly one rising edge after its operands are sampled. The carry words, the selection and the XOR stage settle within the same cycle, and a single register stage follows them. The bench drives operands on a falling edge and compares sum_o and cout_o on the next falling edge, half a period after the capturing edge. A reset applied with nonzero operands is checked the same way, one edge after it is sampled.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int unsigned CWS_DEF_WIDTH = 16;

  typedef enum logic {
    CHAIN_CIN_ZERO = 1'b0,
    CHAIN_CIN_ONE  = 1'b1
  } chain_kind_e;
endpackage

// File: rtl/cws_halfgen.sv
module cws_halfgen #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hs,
  output logic [W-1:0] hc
);
  // bitwise propagate and generate
  assign hs = a ^ b;
  assign hc = a & b;
endmodule

// File: rtl/cws_carrygen.sv
module cws_carrygen
  import cws_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter chain_kind_e KIND = CHAIN_CIN_ZERO
) (
  input  logic [W-1:0] hs,
  input  logic [W-1:0] hc,
  output logic [W-1:0] cw
);
  logic first_bit;

  // the assumed incoming carry only changes the lowest stage
  generate
    if (KIND == CHAIN_CIN_ONE) begin : g_one
      assign first_bit = hs[0] | hc[0];
    end else begin : g_zero
      assign first_bit = hc[0];
    end
  endgenerate

  always_comb begin
    logic run;
    run   = first_bit;
    cw[0] = first_bit;
    for (int unsigned i = 1; i < W; i++) begin
      run   = (run & hs[i]) | hc[i];
      cw[i] = run;
    end
  end
endmodule

// File: rtl/cws_selfinal.sv
module cws_selfinal #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] hs,
  input  logic [W-1:0] cw0,
  input  logic [W-1:0] cw1,
  input  logic         cin,
  output logic [W-1:0] csel,
  output logic [W-1:0] sum,
  output logic         cout
);
  // cw0 implies cw1 per bit, so AND-OR replaces the multiplexer
  assign csel = cw0 | ({W{cin}} & cw1);
  assign cout = csel[W-1];

  generate
    if (W > 1) begin : g_wide
      assign sum = hs ^ {csel[W-2:0], cin};
    end else begin : g_one
      assign sum = hs ^ cin;
    end
  endgenerate
endmodule

// File: rtl/cws_adder.sv
module cws_adder
  import cws_pkg::*;
#(
  parameter int unsigned W = CWS_DEF_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] hs_w, hc_w;
  logic [W-1:0] cw0_w, cw1_w, csel_w;
  logic [W-1:0] sum_w;
  logic         cout_w;

  cws_halfgen #(.W(W)) half_i (
    .a (a_i), .b (b_i), .hs (hs_w), .hc (hc_w)
  );

  cws_carrygen #(.W(W), .KIND(CHAIN_CIN_ZERO)) chain0_i (
    .hs (hs_w), .hc (hc_w), .cw (cw0_w)
  );

  cws_carrygen #(.W(W), .KIND(CHAIN_CIN_ONE)) chain1_i (
    .hs (hs_w), .hc (hc_w), .cw (cw1_w)
  );

  cws_selfinal #(.W(W)) final_i (
    .hs   (hs_w),
    .cw0  (cw0_w),
    .cw1  (cw1_w),
    .cin  (cin_i),
    .csel (csel_w),
    .sum  (sum_w),
    .cout (cout_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_w;
      cout_o <= cout_w;
    end
  end
endmodule

// File: rtl/cws_adder_chk.sv
module cws_adder_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o,
  input logic [W-1:0] cw0,
  input logic [W-1:0] cw1,
  input logic [W-1:0] csel
);
  a_r1_sum_matches: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout_o, sum_o} ==
      ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + (W+1)'($past(cin_i)))));

  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && !cout_o));

  a_r3_carry_order: assert property (@(posedge clk) disable iff (rst)
    (cw0 & ~cw1) == '0);

  a_r4_select_follows_cin: assert property (@(posedge clk) disable iff (rst)
    csel == (cin_i ? cw1 : cw0));

  a_r6_cout_is_top_carry: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cout_o == $past(csel[W-1])));

  a_r7_low_sum_bit: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sum_o[0] == ($past(a_i[0]) ^ $past(b_i[0]) ^ $past(cin_i))));
endmodule

bind cws_adder cws_adder_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .cw0    (cw0_w),
  .cw1    (cw1_w),
  .csel   (csel_w)
);

// File: tb/cws_adder_tb.sv
`timescale 1ns/1ps
module cws_adder_tb_top;
  localparam int unsigned W = 16;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cws_adder #(.W(W)) dut_i (
    .clk (clk), .rst (rst), .a_i (a), .b_i (b), .cin_i (cin),
    .sum_o (sum), .cout_o (cout)
  );

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on a falling edge, compare on the next falling edge
  task automatic add_and_check(input string req, input logic [W-1:0] x,
                               input logic [W-1:0] y, input logic c);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; cin = c;
    exp = {1'b0, x} + {1'b0, y} + (W+1)'(c);
    @(negedge clk);
    check(req, {cout, sum}, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; a = 16'hBEEF; b = 16'h7777; cin = 1'b1;
    @(negedge clk);
    check("R2 reset with operands", {cout, sum}, '0);
    @(negedge clk);
    check("R2 reset held", {cout, sum}, '0);
    rst = 1'b0;
  endtask

  task automatic t_cin_zero();
    add_and_check("R4 ones+0 cin0", ONES, '0, 1'b0);
    check("R4 cout low", {16'd0, cout}, 17'd0);
    add_and_check("R4 mixed cin0", 16'h1234, 16'h0F0F, 1'b0);
  endtask

  task automatic t_cin_one_ripple();
    add_and_check("R5 ones+0 cin1", ONES, '0, 1'b1);
    check("R5 sum zero", {1'b0, sum}, '0);
    add_and_check("R5 0+ones cin1", '0, ONES, 1'b1);
    add_and_check("R5 alternating", 16'h5555, 16'hAAAA, 1'b1);
  endtask

  task automatic t_cout_top();
    add_and_check("R6 ones+ones cin1", ONES, ONES, 1'b1);
    check("R6 cout high", {16'd0, cout}, 17'd1);
    add_and_check("R6 msb only", 16'h8000, 16'h8000, 1'b0);
    add_and_check("R6 just below", 16'h7FFF, 16'h8000, 1'b0);
  endtask

  task automatic t_low_bit();
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] x, y;
      x = {15'h5A3C ^ 15'(i * 977), i[0]};
      y = {15'h1F2E + 15'(i * 313), i[1]};
      @(negedge clk);
      a = x; b = y; cin = i[2];
      @(negedge clk);
      check("R7 sum bit0", {16'd0, sum[0]}, {16'd0, x[0] ^ y[0] ^ i[2]});
    end
  endtask

  task automatic t_sweep();
    logic [31:0] s = 32'h1ACE_B00C;
    for (int i = 0; i < 300; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      add_and_check("R1 sweep", s[15:0], s[31:16], s[7] ^ s[21]);
    end
    // long carry chains across both chains: R3 observed via result
    add_and_check("R3 chain split", 16'h00FF, 16'h0001, 1'b0);
    add_and_check("R3 chain split cin", 16'h00FF, 16'h0000, 1'b1);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 reset state", {cout, sum}, '0);
    rst = 1'b0;
    t_cin_zero();
    t_cin_one_ripple();
    t_cout_top();
    t_low_bit();
    t_reset();
    add_and_check("R1 after reset", 16'hFFFE, 16'h0001, 1'b1);
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule